// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block drives a 16-bit time-multiplexed address/data bus toward up to four slave devices, each reached through its own active-low select line and owning a 64 KB window. A single internal request carries a slave index, a 16-bit offset, a direction flag and write data. The block accepts it only while idle and then steps through five phases: address, wait, data, recovery and idle turnaround.

In the address phase the offset goes out on the shared lines while the latch strobe pulses. The wait phase lasts until the slave pulls its ready line low. Read data is captured on that edge. Write data stays on the lines through the data phase. A counter bounds the wait. If ready never comes, the access is dropped with an error flag.

Bytes follow little-endian order: the low byte of a 16-bit word travels on bits 7:0.

Top module: `mbm_bus_master`

## Requirements
- R1: After reset all selects are high, `ale_o`, `ad_oe_o` and `done_o` are low, and `req_ready_o` is high.
- R2: `req_ready_o` is high only in the idle phase. A request presented while an access is in progress is ignored: the select of the running access does not change.
- R3: The address phase lasts one clock. In it `ale_o` is high, `ad_o` equals the request offset, `ad_oe_o` is high, and only `cs_no[i]` is low, where i is the request's slave index.
- R4: `wnr_o` is 1 for a write and 0 for a read. It is constant, and the selected `cs_no` stays low, from the address phase through the data phase.
- R5: On reads `ad_oe_o` is low after the address phase. On writes `ad_oe_o` is high and `ad_o` carries the write data through wait and data, with data bits 7:0 on lines 7:0.
- R6: The wait phase holds while `rdy_ni` is high. The rising edge that sees `rdy_ni` low ends it, captures `ad_i` as read data, and enters a one-clock data phase.
- R7: The recovery phase lasts one clock. All selects are high, `ad_oe_o` is low, and `done_o` pulses with `err_o` low on success. `rdata_o` holds the last read value and does not change on writes.
- R8: One idle-turnaround clock with `req_ready_o` low follows recovery. Then the block is idle again.
- R9: If `rdy_ni` stays high for `TMO_CYCLES` wait clocks (default 256), the block goes to recovery with `done_o` and `err_o` high and `rdata_o` unchanged. Ready seen low in the last allowed wait clock completes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request accepted |
| req_cs_i | input | 2 | Slave index |
| req_addr_i | input | 16 | Offset within the slave window |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 16 | Write data |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | Timeout flag, valid with done_o |
| rdata_o | output | 16 | Last read data |
| cs_no | output | 4 | Active-low slave selects |
| ale_o | output | 1 | Address latch strobe |
| wnr_o | output | 1 | Write/not-read |
| ad_o | output | 16 | Multiplexed lines, outgoing value |
| ad_oe_o | output | 1 | Drive enable for ad_o |
| ad_i | input | 16 | Multiplexed lines, incoming value |
| rdy_ni | input | 1 | Active-low slave ready |

## Verification
The bench sweeps every slave index against both directions and against ready delays of zero to three wait clocks. This separates select decoding errors from direction handling and from wait counting. Distinct offset, write and read patterns per access expose lane swaps and stale captures. Two boundary runs are tried: one where ready arrives in the last allowed wait clock, and one where ready never arrives. Together they pin the timeout to exactly the configured count. One access holds a competing request through its wait to show that requests are ignored while busy.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_WAIT,
    PH_DATA,
    PH_RECOV,
    PH_TURN
  } phase_e;
endpackage

// File: rtl/mbm_tmo.sv
module mbm_tmo #(
  parameter int TMO_CYCLES = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int CNT_W = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  assign expired_o = run_i && (cnt_q == LAST);

  AST_TMO_COUNT_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(run_i)) |-> (cnt_q == '0)); // R9
endmodule

// File: rtl/mbm_seq.sv
module mbm_seq
  import mbm_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   fire_i,
  input  logic   rdy_ni,
  input  logic   expired_i,
  output phase_e phase_o
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (fire_i) ph_d = PH_ADDR;
      PH_ADDR:  ph_d = PH_WAIT;
      PH_WAIT:  if (!rdy_ni) ph_d = PH_DATA;
                else if (expired_i) ph_d = PH_RECOV;
      PH_DATA:  ph_d = PH_RECOV;
      PH_RECOV: ph_d = PH_TURN;
      PH_TURN:  ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_IDLE;
    else         ph_q <= ph_d;
  end

  assign phase_o = ph_q;

  AST_ADDR_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_ADDR) |-> ($past(ph_q) == PH_IDLE)); // R2
  AST_TURN_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_TURN) |=> (ph_q == PH_IDLE)); // R8
endmodule

// File: rtl/mbm_bus_master.sv
module mbm_bus_master
  import mbm_pkg::*;
#(
  parameter int NCS        = 4,
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int TMO_CYCLES = 256
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic [$clog2(NCS)-1:0] req_cs_i,
  input  logic [AW-1:0]          req_addr_i,
  input  logic                   req_write_i,
  input  logic [DW-1:0]          req_wdata_i,
  output logic                   done_o,
  output logic                   err_o,
  output logic [DW-1:0]          rdata_o,
  output logic [NCS-1:0]         cs_no,
  output logic                   ale_o,
  output logic                   wnr_o,
  output logic [DW-1:0]          ad_o,
  output logic                   ad_oe_o,
  input  logic [DW-1:0]          ad_i,
  input  logic                   rdy_ni
);
  localparam int IDX_W = $clog2(NCS);

  phase_e           phase;
  logic             fire, expired, in_cycle;
  logic [IDX_W-1:0] cs_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic             wr_q, err_q;

  assign fire = req_valid_i && (phase == PH_IDLE);

  mbm_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .rdy_ni    (rdy_ni),
    .expired_i (expired),
    .phase_o   (phase)
  );

  mbm_tmo #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (phase == PH_WAIT),
    .expired_o (expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (fire) begin
        cs_q    <= req_cs_i;
        addr_q  <= req_addr_i;
        wr_q    <= req_write_i;
        wdata_q <= req_wdata_i;
        err_q   <= 1'b0;
      end
      if (phase == PH_WAIT && !rdy_ni && !wr_q) rdata_q <= ad_i;
      if (phase == PH_WAIT && rdy_ni && expired) err_q <= 1'b1;
    end
  end

  assign in_cycle = (phase == PH_ADDR) || (phase == PH_WAIT) || (phase == PH_DATA);

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_no[i] = !(in_cycle && (cs_q == IDX_W'(i)));
  end

  assign ale_o       = (phase == PH_ADDR);
  assign ad_oe_o     = ale_o || (wr_q && (phase == PH_WAIT || phase == PH_DATA));
  assign ad_o        = ale_o ? DW'(addr_q) : wdata_q;  // low byte on [7:0]
  assign wnr_o       = wr_q;
  assign done_o      = (phase == PH_RECOV);
  assign err_o       = done_o && err_q;
  assign req_ready_o = (phase == PH_IDLE);
  assign rdata_o     = rdata_q;

  AST_ONE_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no)); // R3
  AST_ALE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> (!ale_o && (cs_no != '1))); // R3
  AST_WNR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cs_no != '1) && $past(cs_no != '1)) |-> $stable(wnr_o)); // R4
  AST_READ_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wnr_o && !ale_o) |-> !ad_oe_o); // R5
  AST_RECOV_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((cs_no == '1) && !ad_oe_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !req_ready_o)); // R8
  AST_TMO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> $past(rdy_ni)); // R9
endmodule

// File: tb/sim_mbm_bus_master.sv
module sim_mbm_bus_master;
  localparam int TMO = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_cs = '0;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        done, err, ale, wnr, ad_oe;
  logic [15:0] rdata, ad_out;
  logic [15:0] ad_in = 16'hdead;
  logic [3:0]  cs_n;
  logic        rdy_n = 1'b1;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mbm_bus_master #(.TMO_CYCLES(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_cs_i(req_cs),
    .req_addr_i(req_addr), .req_write_i(req_write), .req_wdata_i(req_wdata),
    .done_o(done), .err_o(err), .rdata_o(rdata),
    .cs_no(cs_n), .ale_o(ale), .wnr_o(wnr), .ad_o(ad_out), .ad_oe_o(ad_oe),
    .ad_i(ad_in), .rdy_ni(rdy_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_acc(input int cs, input bit wr, input logic [15:0] a,
                         input logic [15:0] wd, input logic [15:0] rd,
                         input int waits, input bit busy_req);
    bit          tmo = (waits >= TMO);
    logic [3:0]  sel = 4'(~(4'b0001 << cs));
    logic [15:0] prev = rdata;
    int          nw = tmo ? TMO : waits + 1;
    chk("R2 ready in idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_cs = 2'(cs); req_addr = a; req_write = wr; req_wdata = wd;
    step();
    req_valid = 1'b0;
    chk("R3 addr select", 32'(cs_n), 32'(sel));
    chk("R3 ale", 32'(ale), 32'd1);
    chk("R3 addr drive", 32'(ad_oe), 32'd1);
    chk("R3 addr value", 32'(ad_out), 32'(a));
    chk("R4 wnr", 32'(wnr), 32'(wr));
    step();
    for (int i = 0; i < nw; i++) begin
      chk("R4 select held", 32'(cs_n), 32'(sel));
      chk("R3 ale low", 32'(ale), 32'd0);
      chk("R4 wnr held", 32'(wnr), 32'(wr));
      chk("R5 drive", 32'(ad_oe), 32'(wr));
      if (wr) chk("R5 wdata lanes", 32'(ad_out), 32'(wd));
      chk("R2 busy", 32'(req_ready), 32'd0);
      if (busy_req) begin
        req_valid = 1'b1; req_cs = 2'((cs + 1) % 4); req_addr = ~a;
      end
      if (!tmo && i == waits) begin
        rdy_n = 1'b0; ad_in = rd;
      end
      step();
    end
    rdy_n = 1'b1; ad_in = 16'hdead;
    if (!tmo) begin
      chk("R6 data select", 32'(cs_n), 32'(sel));
      chk("R6 no done", 32'(done), 32'd0);
      if (wr) chk("R5 wdata in data", 32'(ad_out), 32'(wd));
      step();
    end
    chk("R7 done", 32'(done), 32'd1);
    chk("R9 err", 32'(err), 32'(tmo));
    chk("R7 release", 32'(cs_n), 32'hf);
    chk("R7 float", 32'(ad_oe), 32'd0);
    chk("R7 R9 rdata", 32'(rdata), 32'((!wr && !tmo) ? rd : prev));
    req_valid = 1'b0;
    step();
    chk("R8 turn done", 32'(done), 32'd0);
    chk("R8 turn busy", 32'(req_ready), 32'd0);
    step();
    chk("R8 back idle", 32'(req_ready), 32'd1);
    chk("R2 no stray access", 32'(cs_n), 32'hf);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 selects", 32'(cs_n), 32'hf);
    chk("R1 ale", 32'(ale), 32'd0);
    chk("R1 drive", 32'(ad_oe), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 ready", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    step();
    for (int cs = 0; cs < 4; cs++)
      for (int wr = 0; wr < 2; wr++)
        for (int w = 0; w < 4; w++) begin
          logic [15:0] a = 16'(16'h1000 * cs + 16'h0111 * w + wr);
          run_acc(cs, bit'(wr), a, a ^ 16'ha55a, 16'(a * 3 + 7), w, 1'b0);
        end
    run_acc(2, 1'b0, 16'h3c3c, 16'h0, 16'h8421, 2, 1'b1);   // R2 busy request
    run_acc(1, 1'b0, 16'h0ff0, 16'h0, 16'h1234, TMO - 1, 1'b0); // R9 edge
    run_acc(3, 1'b0, 16'hbeef, 16'h0, 16'h5678, TMO, 1'b0);     // R9 timeout
    run_acc(0, 1'b1, 16'h0102, 16'h0304, 16'h0, TMO, 1'b0);     // R9 write timeout
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule